// File: doc/BRIEF.md
# Serial Command Register Port

This block is the slave side of a four-wire serial link through which a host reads and writes a bank of 8-bit command registers. Each access is framed by an active-high chip select and lasts exactly sixteen serial clock periods. The host first sends one direction bit and then a seven-bit address field. After that, it either shifts eight data bits in, or collects eight data bits on the serial output. All fields travel least significant bit first.

The serial output is driven only while read data is being presented. At every other moment it is high impedance, so a board may join the input and output into one bidirectional line. The serial clock, chip select and input line are oversampled by a faster system clock. This keeps all storage in one clock domain. A parameterised synchroniser depth sets how many system clocks each serial half period must last.

Top module: `sci_serial_regport`

## Requirements
- R1: A frame is 16 serial clock periods while chip select is high. Bit 1 is the direction bit, bits 2 to 8 are address bits A0..A6, and bits 9 to 16 are data bits D0..D7. Each field is sent LSB first, and the input line is sampled at serial clock rising edges.
- R2: A direction bit of 1 makes the frame a read. A direction bit of 0 makes it a write.
- R3: Address bits A4..A0 (A0 least significant) select one of 32 registers. A6 has no effect on which register is accessed or on whether the access happens.
- R4: On a valid read, the output is enabled after the 8th falling serial clock edge and presents D0 at that point. It then steps through D1..D7 on the following falling edges, so that bit k is stable at rising edge 9+k. The output is released after the 16th falling edge.
- R5: The output enable stays low during the command and address bits of every frame, and during the whole of a write frame.
- R6: Chip select is active high. When it goes low, the output is released, the bit position returns to the start, and any partial frame is abandoned.
- R7: A write frame changes the addressed register only if chip select is still high at the 16th rising edge. A frame cut short changes no register.
- R8: If A5 is received as 1, the frame is invalid. An invalid write changes no register, and an invalid read keeps the output released.
- R9: After reset, all registers hold 0x00 and the output enable is low.
- R10: Read data is the register content taken at the 8th falling edge. Data driven on the input line during a read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high, frames one access |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data, high impedance when not enabled |
| sdo_en | output | 1 | High while sdo is driven |

## Verification
Every one of the 32 addresses is written with a distinct value that is a function of its address, and then read back. This separates swapped or aliased address bits from a plain data path fault. All-ones and all-zeros words, together with the address-derived values, expose bit-order and shift-direction errors within the data field. Frames with A6 set, frames with A5 set, and frames cut short at several bit positions show whether the ignored bit, the guard bit and the commit point are each decoded at the right position. Reads driven with nonzero input data show that a read never writes, and a per-clock check on the output enable shows that the line is quiet outside the read data window.

// File: rtl/sci_pkg.sv
package sci_pkg;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_ADDR,
      PH_DATA,
      PH_DONE
   } sci_phase_e;

   function automatic int frame_len(input int field_w, input int data_w);
      return 1 + field_w + data_w;
   endfunction

endpackage

// File: rtl/sci_sync_edge.sv
module sci_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_i,
   input  logic sdi_i,
   output logic cs_o,
   output logic sdi_o,
   output logic rise_o,
   output logic fall_o
);

   localparam int DEPTH = (STAGES < 1) ? 1 : STAGES;

   logic sclk_s;
   logic sclk_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign sclk_s = sclk_i;
         assign cs_o   = cs_i;
         assign sdi_o  = sdi_i;
      end else begin : g_sync
         logic [2:0] pipe [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) pipe[i] <= 3'b000;
            end else begin
               pipe[0] <= {sclk_i, cs_i, sdi_i};
               for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign sclk_s = pipe[DEPTH-1][2];
         assign cs_o   = pipe[DEPTH-1][1];
         assign sdi_o  = pipe[DEPTH-1][0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise_o = sclk_s & ~sclk_q;
   assign fall_o = ~sclk_s & sclk_q;

endmodule

// File: rtl/sci_regfile.sv
module sci_regfile #(
   parameter int              ADDR_W    = 5,
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int ENTRIES = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [ENTRIES];

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    mem[i] <= RESET_VAL;
            else if (wr_en && (wr_addr == ADDR_W'(i)))     mem[i] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sci_frame_ctrl.sv
module sci_frame_ctrl
   import sci_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int FIELD_W = 7,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = $clog2(sci_pkg::frame_len(FIELD_W, DATA_W) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              sdi,
   input  logic              rise,
   input  logic              fall,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo_bit,
   output logic              sdo_en,
   output logic              dir_o,
   output logic              guard_o,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam int FRAME_LEN  = frame_len(FIELD_W, DATA_W);
   localparam int DATA_FIRST = 1 + FIELD_W;

   logic [CNT_W-1:0]   cnt;
   logic               dir;
   logic [FIELD_W-1:0] addr_sh;
   logic [DATA_W-1:0]  data_sh;
   logic [DATA_W-1:0]  out_sh;
   logic               oe;
   sci_phase_e         phase;

   always_comb begin
      if (cnt == '0)                          phase = PH_CMD;
      else if (cnt < CNT_W'(DATA_FIRST))      phase = PH_ADDR;
      else if (cnt < CNT_W'(FRAME_LEN))       phase = PH_DATA;
      else                                    phase = PH_DONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         dir     <= 1'b0;
         addr_sh <= '0;
         data_sh <= '0;
         out_sh  <= '0;
         oe      <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (!cs) begin
            cnt <= '0;
            oe  <= 1'b0;
         end else if (rise && phase != PH_DONE) begin
            cnt <= cnt + 1'b1;
            case (phase)
               PH_CMD:  dir     <= sdi;
               PH_ADDR: addr_sh <= {sdi, addr_sh[FIELD_W-1:1]};
               default: data_sh <= {sdi, data_sh[DATA_W-1:1]};
            endcase
            if (cnt == CNT_W'(FRAME_LEN - 1) && !dir && !addr_sh[ADDR_W]) begin
               wr_en   <= 1'b1;
               wr_addr <= addr_sh[ADDR_W-1:0];
               wr_data <= {sdi, data_sh[DATA_W-1:1]};
            end
         end else if (fall) begin
            if (cnt == CNT_W'(DATA_FIRST)) begin
               out_sh <= rd_data;
               oe     <= dir && !addr_sh[ADDR_W];
            end else if (phase == PH_DATA) begin
               out_sh <= out_sh >> 1;
            end else if (phase == PH_DONE) begin
               oe <= 1'b0;
            end
         end
      end
   end

   assign rd_addr = addr_sh[ADDR_W-1:0];
   assign sdo_bit = out_sh[0];
   assign sdo_en  = oe;
   assign dir_o   = dir;
   assign guard_o = addr_sh[ADDR_W];
   assign cnt_o   = cnt;

endmodule

// File: rtl/sci_serial_regport.sv
module sci_serial_regport #(
   parameter int              ADDR_W      = 5,
   parameter int              FIELD_W     = 7,
   parameter int              DATA_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sclk,
   input  logic sdi,
   output logic sdo,
   output logic sdo_en
);

   localparam int FRAME_LEN = sci_pkg::frame_len(FIELD_W, DATA_W);
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);

   generate
      if (FIELD_W < ADDR_W + 1) begin : g_bad_field
         $error("address field must hold the address plus the guard bit");
      end
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
         $error("address and data widths out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("synchroniser depth must be 0 to 4");
      end
   endgenerate

   logic              cs_s;
   logic              sdi_s;
   logic              sclk_rise;
   logic              sclk_fall;
   logic [DATA_W-1:0] rd_data;
   logic [ADDR_W-1:0] rd_addr;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              sdo_bit;
   logic              oe;
   logic              dir;
   logic              guard;
   logic [CNT_W-1:0]  cnt;

   sci_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk),
      .cs_i   (cs),
      .sdi_i  (sdi),
      .cs_o   (cs_s),
      .sdi_o  (sdi_s),
      .rise_o (sclk_rise),
      .fall_o (sclk_fall)
   );

   sci_frame_ctrl #(
      .ADDR_W  (ADDR_W),
      .FIELD_W (FIELD_W),
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs_s),
      .sdi     (sdi_s),
      .rise    (sclk_rise),
      .fall    (sclk_fall),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sdo_bit (sdo_bit),
      .sdo_en  (oe),
      .dir_o   (dir),
      .guard_o (guard),
      .cnt_o   (cnt)
   );

   sci_regfile #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .RESET_VAL (RESET_VAL)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign sdo_en = oe;
   assign sdo    = oe ? sdo_bit : 1'bz;

endmodule

// File: rtl/sci_serial_regport_chk.sv
module sci_serial_regport_chk #(
   parameter int FRAME_LEN  = 16,
   parameter int DATA_FIRST = 8,
   parameter int CNT_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_s,
   input logic             sclk_fall,
   input logic             oe,
   input logic             sdo_bit,
   input logic             dir,
   input logic             guard,
   input logic             wr_en,
   input logic [CNT_W-1:0] cnt
);

   // R1: the bit position never runs past the frame
   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(FRAME_LEN));

   // R4: output data moves only after a falling serial edge
   a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(sdo_bit));

   // R5: no drive before the data field
   a_r5_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> cnt >= CNT_W'(DATA_FIRST));

   // R5: no drive on a write
   a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> dir);

   // R6: chip select low releases the line next cycle
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !oe);

   // R7: a register update follows only a complete write frame
   a_r7_commit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cnt == CNT_W'(FRAME_LEN)) && !dir && !guard);

   // R8: a frame with the guard bit set never drives
   a_r8_guard: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> !guard);

endmodule

bind sci_serial_regport sci_serial_regport_chk #(
   .FRAME_LEN  (FRAME_LEN),
   .DATA_FIRST (1 + FIELD_W),
   .CNT_W      (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_s      (cs_s),
   .sclk_fall (sclk_fall),
   .oe        (oe),
   .sdo_bit   (sdo_bit),
   .dir       (dir),
   .guard     (guard),
   .wr_en     (wr_en),
   .cnt       (cnt)
);

// File: tb/sci_serial_regport_tb.sv
module sci_serial_regport_tb;

   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   wire  sdo;
   logic sdo_en;

   int total = 0;
   int bad = 0;
   bit quiet = 1'b0;
   bit done = 1'b0;
   logic [7:0] model [32];

   always #2 clk = ~clk;

   sci_serial_regport u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs     (cs),
      .sclk   (sclk),
      .sdi    (sdi),
      .sdo    (sdo),
      .sdo_en (sdo_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R5: per-clock check while the line must stay quiet
   always @(negedge clk) begin
      if (rst_n && quiet && !done) chk(sdo_en == 1'b0, "R5 quiet", sdo_en, 0);
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One frame of nbits serial periods; rd=1 read, afield = A6..A0
   task automatic frame(input bit rd, input logic [6:0] afield,
                        input logic [7:0] wd, input int nbits);
      logic [7:0] exp_rd;
      bit valid;
      exp_rd = model[afield[4:0]];
      valid  = !afield[5];
      quiet  = 1'b1;
      cs = 1'b1;
      sclk = 1'b0;
      wait_clk(4);
      for (int k = 1; k <= nbits; k++) begin
         if (k == 1)      sdi = rd;
         else if (k <= 8) sdi = afield[k-2];
         else             sdi = wd[k-9];
         sclk = 1'b0;
         if (k == 9 && rd) quiet = 1'b0;
         wait_clk(HALF);
         if (k >= 9 && rd && valid) begin
            chk(sdo_en == 1'b1, "R4 enable", sdo_en, 1);
            chk(sdo == exp_rd[k-9], "R4 data bit", sdo, exp_rd[k-9]);
         end else begin
            chk(sdo_en == 1'b0, rd ? "R8 guard read" : "R5 idle", sdo_en, 0);
         end
         sclk = 1'b1;
         wait_clk(HALF);
      end
      sclk = 1'b0;
      wait_clk(HALF);
      if (nbits == 16) chk(sdo_en == 1'b0, "R4 release", sdo_en, 0);
      cs = 1'b0;
      wait_clk(6);
      quiet = 1'b1;
      chk(sdo_en == 1'b0, "R6 cs low", sdo_en, 0);
      wait_clk(4);
      if (nbits == 16 && !rd && valid) model[afield[4:0]] = wd;
   endtask

   initial begin
      for (int a = 0; a < 32; a++) model[a] = 8'h00;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      chk(sdo_en == 1'b0, "R9 reset enable", sdo_en, 0);

      // R9: registers read zero after reset
      frame(1'b1, 7'd0, 8'h00, 16);
      frame(1'b1, 7'd31, 8'hFF, 16);

      // R1 R2 R3: write then read every address
      for (int a = 0; a < 32; a++) frame(1'b0, 7'(a), 8'(a * 29) ^ 8'hA5, 16);
      for (int a = 0; a < 32; a++) frame(1'b1, 7'(a), 8'h00, 16);

      // R1: extreme words
      frame(1'b0, 7'd3, 8'hFF, 16);
      frame(1'b0, 7'd4, 8'h00, 16);
      frame(1'b1, 7'd3, 8'h00, 16);
      frame(1'b1, 7'd4, 8'hFF, 16);

      // R3: A6 set has no effect
      frame(1'b0, 7'h49, 8'h77, 16);
      frame(1'b1, 7'h09, 8'h00, 16);
      frame(1'b1, 7'h49, 8'h00, 16);

      // R8: guard bit set, write ignored and read stays released
      frame(1'b0, 7'h27, 8'h3C, 16);
      frame(1'b1, 7'h07, 8'h00, 16);
      frame(1'b1, 7'h27, 8'h00, 16);

      // R7: frames cut short before the commit edge
      frame(1'b0, 7'd10, 8'h11, 15);
      frame(1'b0, 7'd10, 8'h22, 9);
      frame(1'b0, 7'd10, 8'h33, 4);
      frame(1'b1, 7'd10, 8'h00, 16);

      // R6: read cut short, next frame starts from bit one
      frame(1'b1, 7'd12, 8'h00, 12);
      frame(1'b1, 7'd12, 8'h00, 16);

      // R10: input data during a read writes nothing
      frame(1'b1, 7'd20, 8'h5A, 16);
      frame(1'b1, 7'd20, 8'h00, 16);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule